// File: doc/BRIEF.md
# Decode-Error Interrupt Register Bank

This block holds the interrupt registers for the receive decoder of a serial gigabit PHY. Single-cycle error pulses from the decoder set sticky bits in an 8-bit status register. A mask register selects which status bits can raise the one interrupt output. That output is registered.

Status bits cannot be cleared by writing to them. Software first loads a clear-select register with the bits it wants removed. It then sets a global-clear command bit. A fixed number of cycles after that command write, the block removes the selected bits in a single cycle. Software polls the status register until those bits read back as zero. It then ends the handshake by writing zero to the command register and to the clear-select register. Register access uses a simple port: writes are strobed, and reads are combinational from the address.

Top module: `phy_irq_bank`

## Requirements
- R1: Reset (synchronous, active low) sets the command, clear-select, mask and status registers to zero and drives `irq_out` low.
- R2: A high bit on `evt_pulse` in a cycle sets the matching status bit from the next cycle on. The bit stays set until a clear removes it. Bit 7 marks a code-group decode error and bit 6 marks a running-disparity error.
- R3: The register map is: command at 0x0AC (bit 0 is the global-clear command), clear-select at 0x0B0, mask at 0x0B4, status at 0x0B8. All registers are 32 bits wide and any bit above the implemented field reads zero. Writes to the status register have no effect. Unmapped addresses read zero.
- R4: `irq_out` equals the OR over all bits of (status AND mask), delayed by one register stage.
- R5: A mask of zero keeps `irq_out` low whatever the status holds. A mask of 0xC0 lets only bits 7 and 6 raise the interrupt. The mask never alters the status.
- R6: A write that changes command bit 0 from 0 to 1 starts the clear. Exactly CLR_DELAY clock edges after that write edge, the status bits selected in clear-select are removed and all other status bits are kept.
- R7: The clear takes effect only while command bit 0 stays set. Writing it back to 0 before the delay ends cancels the clear. Writing 1 while it is already 1 does not restart the delay.
- R8: An error event that arrives in the same cycle as the clear of its bit wins, and the bit stays set.
- R9: The command and clear-select registers keep their written values until software writes them again, so the handshake ends only when software writes zero to both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 12 | Byte address of the register for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 8 | Error event pulses, one per status bit |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with CLR_DELAY set to 5 rather than the default 4. A status read one cycle before expiry and another one cycle after it therefore pin the exact clear edge to the parameter and not to a constant. With that delay the bench can place an event pulse on the very edge where a clear fires. It can also drop the command mid-count and re-set it mid-count, and show that the countdown is cancelled in the first case and not restarted in the second.

// File: rtl/phy_irq_pkg.sv
// Package: shared constants and the register-select type for the
// decode-error interrupt bank. Assumes a 12-bit byte address space.
package phy_irq_pkg;

    localparam int ADDR_W = 12;

    // Register byte offsets (software-visible map)
    localparam logic [ADDR_W-1:0] OFS_CMD  = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFS_MASK = 12'h0B4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h0B8;

    // Bit positions with fixed meaning
    localparam int BIT_GCLR     = 0;
    localparam int BIT_CODE_ERR = 7;
    localparam int BIT_DISP_ERR = 6;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_CLR,
        SEL_MASK,
        SEL_STAT
    } reg_sel_e;

    // Map a byte address onto a register select
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CMD:  s = SEL_CMD;
            OFS_CLR:  s = SEL_CLR;
            OFS_MASK: s = SEL_MASK;
            OFS_STAT: s = SEL_STAT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_ctrl_regs.sv
// Module: irq_ctrl_regs
// Holds the software-written control registers: global-clear command,
// clear-select and mask. Also flags the write that takes the command
// bit from 0 to 1, which is what starts the delayed clear.
// Assumes: wr_data is already cut down to the implemented field width.
module irq_ctrl_regs
    import phy_irq_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    output logic              cmd_q,
    output logic [STAT_W-1:0] clr_sel_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              cmd_set_wr
);

    logic wr_cmd;
    logic wr_clr;
    logic wr_mask;

    // Per-register write enables
    always_comb begin
        wr_cmd  = wr_en && (wr_sel == SEL_CMD);
        wr_clr  = wr_en && (wr_sel == SEL_CLR);
        wr_mask = wr_en && (wr_sel == SEL_MASK);
    end

    // Start condition: command bit written to 1 while it was 0
    always_comb begin
        cmd_set_wr = wr_cmd && wr_data[BIT_GCLR] && !cmd_q;
    end

    // Command register: one implemented bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 1'b0;
        end else if (wr_cmd) begin
            cmd_q <= wr_data[BIT_GCLR];
        end
    end

    // Clear-select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_sel_q <= '0;
        end else if (wr_clr) begin
            clr_sel_q <= wr_data;
        end
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= wr_data;
        end
    end

    // R9: command holds its value unless written
    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmd |=> $stable(cmd_q));

    // R9: clear-select holds its value unless written
    assert_clr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clr |=> $stable(clr_sel_q));

endmodule

// File: rtl/irq_clear_seq.sv
// Module: irq_clear_seq
// Times the delayed clear. A start write loads a down-counter. The
// clear fires for one cycle when the count has run out, provided the
// command bit is still set. Dropping the command disarms the counter.
// Assumes: CLR_DELAY >= 1. cmd_set_wr is only high when cmd_q is low.
module irq_clear_seq #(
    parameter int CLR_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_set_wr,
    input  logic cmd_q,
    output logic clr_fire
);

    localparam int CNT_W = (CLR_DELAY > 1) ? $clog2(CLR_DELAY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CLR_DELAY - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // One-cycle clear strobe at the end of the countdown
    always_comb begin
        clr_fire = armed_q && cmd_q && (cnt_q == '0);
    end

    // Countdown: load on start, cancel on command drop, stop on fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (cmd_set_wr) begin
            armed_q <= 1'b1;
            cnt_q   <= CNT_LOAD;
        end else if (!cmd_q) begin
            armed_q <= 1'b0;
        end else if (armed_q) begin
            if (cnt_q == '0) begin
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7: no clear unless the command bit is set
    assert_fire_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |-> cmd_q);

    // R6: the clear strobe lasts exactly one cycle
    assert_fire_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> !clr_fire);

    // R7: a cancelled countdown never fires afterwards
    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_q && !cmd_set_wr) |=> !clr_fire);

endmodule

// File: rtl/irq_status_bits.sv
// Module: irq_status_bits
// Sticky status bits and the registered interrupt line. Each bit is set
// by its event pulse and removed by the clear strobe when selected. An
// event beats a clear that lands in the same cycle.
// Assumes: clr_fire is a single-cycle strobe.
module irq_status_bits #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt,
    input  logic              clr_fire,
    input  logic [STAT_W-1:0] clr_sel,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq_q
);

    genvar gi;
    generate
        for (gi = 0; gi < STAT_W; gi++) begin : g_bit
            logic kill;

            // Clear applies to this bit when strobed and selected
            always_comb begin
                kill = clr_fire && clr_sel[gi];
            end

            // Sticky bit: event has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[gi] <= 1'b0;
                end else if (evt[gi]) begin
                    stat_q[gi] <= 1'b1;
                end else if (kill) begin
                    stat_q[gi] <= 1'b0;
                end
            end
        end
    endgenerate

    // Registered interrupt from masked status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_q & mask);
        end
    end

    // R2: every event bit is visible in status one cycle later
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

    // R2: with no event and no clear, status does not move
    assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0 && !clr_fire) |=> $stable(stat_q));

    // R6: selected bits without a competing event are gone after a clear
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> ((stat_q & $past(clr_sel & ~evt)) == '0));

    // R6: unselected bits survive a clear
    assert_clear_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> ((stat_q & $past(~clr_sel)) == ($past(stat_q) & $past(~clr_sel))));

    // R8: an event coinciding with the clear keeps its bit set
    assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fire && ((evt & clr_sel) != '0)) |=> ((stat_q & $past(evt & clr_sel)) != '0));

    // R4: the interrupt only rises after a masked status bit was present
    assert_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(stat_q & mask) != '0));

    // R5: a zero mask keeps the interrupt low one cycle later
    assert_mask_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq_q);

endmodule

// File: rtl/phy_irq_bank.sv
// Module: phy_irq_bank (top)
// Interrupt register bank for the receive decoder of a serial gigabit
// PHY. Decodes the register port, holds the control registers, times
// the delayed clear, keeps the sticky status and drives the interrupt.
// Assumes: STAT_W < DATA_W. The read path is combinational from reg_addr.
module phy_irq_bank
    import phy_irq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 8,
    parameter int CLR_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] evt_pulse,
    output logic              irq_out
);

    reg_sel_e          sel;
    logic              cmd_q;
    logic [STAT_W-1:0] clr_sel_q;
    logic [STAT_W-1:0] mask_q;
    logic              cmd_set_wr;
    logic              clr_fire;
    logic [STAT_W-1:0] stat_q;
    logic              irq_q;
    logic              wdata_unused;

    // Address decode shared by the read and write paths
    always_comb begin
        sel = decode_addr(reg_addr);
    end

    // Upper write-data bits carry nothing
    always_comb begin
        wdata_unused = ^reg_wdata[DATA_W-1:STAT_W];
    end

    irq_ctrl_regs #(
        .STAT_W (STAT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_sel     (sel),
        .wr_data    (reg_wdata[STAT_W-1:0]),
        .cmd_q      (cmd_q),
        .clr_sel_q  (clr_sel_q),
        .mask_q     (mask_q),
        .cmd_set_wr (cmd_set_wr)
    );

    irq_clear_seq #(
        .CLR_DELAY (CLR_DELAY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_set_wr (cmd_set_wr),
        .cmd_q      (cmd_q),
        .clr_fire   (clr_fire)
    );

    irq_status_bits #(
        .STAT_W (STAT_W)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .clr_fire (clr_fire),
        .clr_sel  (clr_sel_q),
        .mask     (mask_q),
        .stat_q   (stat_q),
        .irq_q    (irq_q)
    );

    // Read mux: implemented field in the low bits, zeros above
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CMD:  reg_rdata[BIT_GCLR]   = cmd_q;
            SEL_CLR:  reg_rdata[STAT_W-1:0] = clr_sel_q;
            SEL_MASK: reg_rdata[STAT_W-1:0] = mask_q;
            SEL_STAT: reg_rdata[STAT_W-1:0] = stat_q;
            default:  reg_rdata = '0;
        endcase
    end

    // Interrupt output
    always_comb begin
        irq_out = irq_q;
    end

    // R3: bits above the implemented field always read zero
    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:STAT_W] == '0);

    // R3: an unmapped address reads zero
    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (reg_rdata == '0));

    // R1: right after reset the interrupt is low
    assert_reset_irq_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

endmodule

// File: tb/phy_irq_bank_test.sv
// Bench for phy_irq_bank. The driver tasks push expected values into a
// scoreboard queue. A monitor process pops each item and compares it
// with the live port value.
module phy_irq_bank_test;

    localparam int DLY = 5;
    localparam logic [11:0] A_CMD  = 12'h0AC;
    localparam logic [11:0] A_CLR  = 12'h0B0;
    localparam logic [11:0] A_MASK = 12'h0B4;
    localparam logic [11:0] A_STAT = 12'h0B8;

    typedef struct {
        bit          is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        irq_out;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    item_t sb_q[$];
    event  mon_ev;

    always #4 clk = ~clk;

    phy_irq_bank #(
        .DATA_W    (32),
        .STAT_W    (8),
        .CLR_DELAY (DLY)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_out   (irq_out)
    );

    // Monitor: compare every queued expectation with the port value
    always @(mon_ev) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0;
        it.addr = a;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        #1;
        ->mon_ev;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1;
        it.addr = '0;
        it.exp = {31'b0, e};
        it.tag = tag;
        sb_q.push_back(it);
        #1;
        ->mon_ev;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] b);
        evt_pulse = b;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        rd(A_CMD, 32'h0, "R1 cmd after reset");
        rd(A_CLR, 32'h0, "R1 clr after reset");
        rd(A_MASK, 32'h0, "R1 mask after reset");
        rd(A_STAT, 32'h0, "R1 status after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R2: both decode errors latch; R5: zero mask keeps irq low
        pulse(8'hC0);
        rd(A_STAT, 32'hC0, "R2 code and disparity bits set");
        chk_irq(1'b0, "R5 zero mask blocks irq");

        // R4: one-cycle registered interrupt after the mask enables it
        wr(A_MASK, 32'hC0);
        chk_irq(1'b0, "R4 irq not yet up in write cycle");
        chk_irq(1'b1, "R4 irq up one cycle later");
        rd(A_MASK, 32'hC0, "R5 mask reads decode bits");

        // R6: clear only bit 7, exactly DLY edges after the command write
        wr(A_CLR, 32'h80);
        wr(A_CMD, 32'h1);
        idle(DLY - 1);
        rd(A_STAT, 32'hC0, "R6 status kept before delay ends");
        rd(A_STAT, 32'h40, "R6 selected bit cleared, other kept");
        chk_irq(1'b1, "R4 irq stays for bit 6");

        // R9: registers hold until software finishes the handshake
        rd(A_CMD, 32'h1, "R9 command held");
        rd(A_CLR, 32'h80, "R9 clear-select held");
        wr(A_CMD, 32'h0);
        wr(A_CLR, 32'h0);
        rd(A_CMD, 32'h0, "R9 command zero after finish");
        rd(A_CLR, 32'h0, "R9 clear-select zero after finish");

        // R8: an event on the clear edge wins
        wr(A_CLR, 32'h40);
        wr(A_CMD, 32'h1);
        idle(DLY - 1);
        pulse(8'h40);
        rd(A_STAT, 32'h40, "R8 event beats clear");
        wr(A_CMD, 32'h0);
        wr(A_CLR, 32'h0);

        // R6 and R4: plain clear of bit 6, irq drops one cycle later
        wr(A_CLR, 32'h40);
        wr(A_CMD, 32'h1);
        idle(DLY);
        chk_irq(1'b1, "R4 irq still up on clear edge");
        rd(A_STAT, 32'h0, "R6 bit 6 cleared");
        chk_irq(1'b0, "R4 irq down after clear");
        wr(A_CMD, 32'h0);
        wr(A_CLR, 32'h0);

        // R7: dropping the command mid-count cancels the clear
        pulse(8'h80);
        wr(A_CLR, 32'h80);
        wr(A_CMD, 32'h1);
        wr(A_CMD, 32'h0);
        idle(2 * DLY);
        rd(A_STAT, 32'h80, "R7 cancelled clear leaves bit");

        // R7: a second set write does not restart the count
        wr(A_CMD, 32'h1);
        idle(2);
        wr(A_CMD, 32'h1);
        idle(DLY - 4);
        rd(A_STAT, 32'h80, "R7 bit kept just before original expiry");
        rd(A_STAT, 32'h0, "R7 cleared at original expiry");
        wr(A_CMD, 32'h0);
        wr(A_CLR, 32'h0);

        // R3: map, unused bits, status not writable, unmapped address
        pulse(8'h04);
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h04, "R3 status write ignored");
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_CLR, 32'h0000_00FF, "R3 clear-select upper bits zero");
        wr(A_CLR, 32'h0);
        wr(A_CMD, 32'hFFFF_FFFE);
        rd(A_CMD, 32'h0, "R3 command only bit 0");
        rd(12'h0A8, 32'h0, "R3 unmapped reads zero");
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, 32'h0000_00FF, "R3 mask upper bits zero");
        chk_irq(1'b1, "R4 irq from bit 2 under full mask");

        // R5: zero mask disables, mask leaves status alone
        wr(A_MASK, 32'h0);
        idle(1);
        chk_irq(1'b0, "R5 mask zero disables irq");
        rd(A_STAT, 32'h04, "R5 mask does not alter status");

        // R5: decode-only mask ignores bit 2, passes bit 6
        wr(A_MASK, 32'hC0);
        idle(1);
        chk_irq(1'b0, "R5 non-decode bit masked");
        pulse(8'h40);
        idle(1);
        chk_irq(1'b1, "R5 decode bit raises irq");

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        rd(A_STAT, 32'h0, "R1 status after mid reset");
        rd(A_MASK, 32'h0, "R1 mask after mid reset");
        chk_irq(1'b0, "R1 irq after mid reset");

        done = 1;
        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule